// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Register Control

This block sends stereo audio over a three-wire serial audio link (I2S framing). A host loads left and right samples through a 32-bit register port. Each write to the right-sample register pushes a complete pair into a transmit FIFO. The serializer draws one pair from the FIFO at the start of every left half-frame and shifts each word out MSB first. Bit timing comes from an externally supplied bit clock and word-select strobe, which are sampled in the system clock domain.

Three separate enables must all be set before samples leave the FIFO: a global one, a transmit-block one and a channel one. While any of them is clear the line carries zeros and the FIFO keeps its contents. A coded field sets the sample width. The host can also program a FIFO level threshold, flush the FIFO, and mask the two interrupt sources: FIFO at or below the threshold, and write-while-full overrun.

Top module: `i2s_tx_core`

## Requirements
- R1: After reset the serial output is 0 and the interrupt is 0. The enables at 0x000, 0x008 and 0x02C read 0, the width code reads 2, the mask reads 0x30, the threshold reads 0 and the status reads 0x10 (empty FIFO, threshold 0).
- R2: Bit 0 of the global enable (0x000), the transmit-block enable (0x008) and the channel enable (0x02C) is writable and reads back. All other bits of these registers read 0.
- R3: A write to 0x020 stages a left sample. A write to 0x024 pushes the staged left sample and the written right sample into the FIFO as one pair. The FIFO holds FIFO_DEPTH pairs and sends them in write order.
- R4: Each half-frame is a 32-bit slot. The left word goes out while word select is low. Its MSB appears on the bit-clock period that follows the word-select change. The output changes only after a falling edge of the bit clock, and slot bits below the sample are sent as 0.
- R5: Bits 2:0 of 0x034 select the sample width. Code 2 selects 16 bits, 4 selects 24 and 5 selects 32; code 1 selects 12 and 3 selects 20; any other code selects 32. The lowest width bits of each written sample are sent.
- R6: A pair is removed from the FIFO and sent only when all three enables are 1 at the start of a left half-frame. Otherwise both words of that frame are zero and the FIFO level does not change.
- R7: If the FIFO is empty at the start of a left half-frame while enabled, both words of that frame are zero.
- R8: Status bit 4 at 0x038 and `fifo_low_o` are 1 exactly when the FIFO level is at or below the threshold held in 0x04C.
- R9: A right-sample write while the FIFO is full is discarded and sets the overrun flag (status bit 5, `overrun_o`). A read or a write of 0x044 clears the flag.
- R10: Bits 5:4 of 0x03C mask the threshold source and the overrun source; 1 masks. `irq_o` is 1 when any unmasked source is 1.
- R11: Writing 1 to bit 0 of 0x018 empties the FIFO. Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 9 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| sck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select, low for left |
| sd_o | output | 1 | Serial data |
| irq_o | output | 1 | Combined unmasked interrupt |
| fifo_low_o | output | 1 | FIFO level at or below threshold |
| overrun_o | output | 1 | Latched overrun flag |

## Verification
Several rules are checked every cycle, next to the logic they guard. The FIFO level never exceeds its depth, and a flush leaves it empty. A pop happens only when the block is enabled and the FIFO is not empty. The serial line moves only on a bit-clock fall. The overrun flag sets on a write while full and clears on an access to the clear register. Word order, MSB-first alignment at each width code, zero frames after the FIFO drains, the discarded ninth pair, and the level being kept while any enable is off can only be shown by the bench. It decodes the serial stream as a receiver would and compares it with samples it generated itself.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

  localparam int REG_AW = 9;

  localparam logic [REG_AW-1:0] A_GLB_EN  = 9'h000;
  localparam logic [REG_AW-1:0] A_BLK_EN  = 9'h008;
  localparam logic [REG_AW-1:0] A_FLUSH   = 9'h018;
  localparam logic [REG_AW-1:0] A_LEFT    = 9'h020;
  localparam logic [REG_AW-1:0] A_RIGHT   = 9'h024;
  localparam logic [REG_AW-1:0] A_CH_EN   = 9'h02C;
  localparam logic [REG_AW-1:0] A_RES     = 9'h034;
  localparam logic [REG_AW-1:0] A_STAT    = 9'h038;
  localparam logic [REG_AW-1:0] A_MASK    = 9'h03C;
  localparam logic [REG_AW-1:0] A_OVR_CLR = 9'h044;
  localparam logic [REG_AW-1:0] A_THR     = 9'h04C;

  // bit positions of the two interrupt sources (status and mask)
  localparam int BIT_LOW = 4;
  localparam int BIT_OVR = 5;

  typedef struct packed {
    logic glb;
    logic blk;
    logic ch;
  } enables_t;

  // sample width selected by the resolution code
  function automatic int unsigned res_width(input logic [2:0] code);
    case (code)
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/i2stx_fifo.sv
module i2stx_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             push_ok, pop_ok;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_ptr_q];
  assign level   = lvl_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    lvl_d    = lvl_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      lvl_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = bump(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = bump(rd_ptr_q);
      if (push_ok && !pop_ok)      lvl_d = lvl_q + 1'b1;
      else if (pop_ok && !push_ok) lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      lvl_q    <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full);

endmodule

// File: rtl/i2stx_regs.sv
module i2stx_regs
  import i2stx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [LVL_W-1:0]    fifo_level,
  input  logic                fifo_full,
  output enables_t            en,
  output logic [2:0]          res_code,
  output logic                push,
  output logic [2*DATA_W-1:0] push_data,
  output logic                flush,
  output logic                low_flag,
  output logic                ovr_flag,
  output logic                irq
);

  enables_t          en_q, en_d;
  logic [2:0]        res_q, res_d;
  logic [1:0]        mask_q, mask_d;
  logic [LVL_W-1:0]  thr_q, thr_d;
  logic [DATA_W-1:0] left_q;
  logic              left_we;
  logic              ovr_q, ovr_d;
  logic              clr_access;

  assign left_we    = wr_en && (addr == A_LEFT);
  assign clr_access = (wr_en || rd_en) && (addr == A_OVR_CLR);
  assign push_data  = {left_q, wdata};

  always_comb begin
    en_d   = en_q;
    res_d  = res_q;
    mask_d = mask_q;
    thr_d  = thr_q;
    ovr_d  = ovr_q;
    push   = 1'b0;
    flush  = 1'b0;
    if (wr_en) begin
      case (addr)
        A_GLB_EN: en_d.glb = wdata[0];
        A_BLK_EN: en_d.blk = wdata[0];
        A_CH_EN:  en_d.ch  = wdata[0];
        A_RES:    res_d    = wdata[2:0];
        A_MASK:   mask_d   = wdata[BIT_OVR:BIT_LOW];
        A_THR:    thr_d    = wdata[LVL_W-1:0];
        A_FLUSH:  flush    = wdata[0];
        A_RIGHT: begin
          if (fifo_full) ovr_d = 1'b1;
          else           push  = 1'b1;
        end
        default: ;
      endcase
    end
    if (clr_access) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      res_q  <= 3'd2;
      mask_q <= 2'b11;
      thr_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      res_q  <= res_d;
      mask_q <= mask_d;
      thr_q  <= thr_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_we) left_q <= wdata;
  end

  assign en       = en_q;
  assign res_code = res_q;
  assign low_flag = (fifo_level <= thr_q);
  assign ovr_flag = ovr_q;
  assign irq      = (low_flag && !mask_q[0]) || (ovr_q && !mask_q[1]);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_GLB_EN:  rdata[0] = en_q.glb;
        A_BLK_EN:  rdata[0] = en_q.blk;
        A_CH_EN:   rdata[0] = en_q.ch;
        A_RES:     rdata[2:0] = res_q;
        A_MASK:    rdata[BIT_OVR:BIT_LOW] = mask_q;
        A_THR:     rdata[LVL_W-1:0] = thr_q;
        A_OVR_CLR: rdata[0] = ovr_q;
        A_STAT: begin
          rdata[BIT_LOW] = low_flag;
          rdata[BIT_OVR] = ovr_q;
        end
        default: ;
      endcase
    end
  end

  assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_RIGHT && fifo_full) |=> ovr_flag);

  assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_access |=> !ovr_flag);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (low_flag || ovr_flag));

endmodule

// File: rtl/i2stx_serial.sv
module i2stx_serial
  import i2stx_pkg::*;
#(
  parameter int SLOT = 32,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              active,
  input  logic              fifo_empty,
  input  logic [2*SLOT-1:0] head,
  input  logic [2:0]        res_code,
  output logic              pop,
  output logic              sd_o
);

  logic [SYNC-1:0] sck_sync, ws_sync;
  logic            sck_old;
  logic            fall, ws_cur;
  logic            ws_prev_q, ws_prev_d;
  logic [SLOT-1:0] shreg_q, shreg_d, rhold_q, rhold_d;
  logic            sd_q, sd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      ws_sync  <= '0;
      sck_old  <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[SYNC-2:0], sck_i};
      ws_sync  <= {ws_sync[SYNC-2:0], ws_i};
      sck_old  <= sck_sync[SYNC-1];
    end
  end

  assign fall   = sck_old && !sck_sync[SYNC-1];
  assign ws_cur = ws_sync[SYNC-1];

  function automatic logic [SLOT-1:0] align(input logic [SLOT-1:0] s,
                                            input logic [2:0] code);
    int unsigned nb;
    nb = res_width(code);
    if (nb > SLOT) nb = SLOT;
    return s << (SLOT - nb);
  endfunction

  always_comb begin
    shreg_d   = shreg_q;
    rhold_d   = rhold_q;
    sd_d      = sd_q;
    ws_prev_d = ws_prev_q;
    pop       = 1'b0;
    if (fall) begin
      sd_d      = shreg_q[SLOT-1];
      shreg_d   = shreg_q << 1;
      ws_prev_d = ws_cur;
      if (ws_cur != ws_prev_q) begin
        if (!ws_cur) begin
          if (active && !fifo_empty) begin
            pop     = 1'b1;
            shreg_d = align(head[2*SLOT-1:SLOT], res_code);
            rhold_d = align(head[SLOT-1:0], res_code);
          end else begin
            shreg_d = '0;
            rhold_d = '0;
          end
        end else begin
          shreg_d = active ? rhold_q : '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      rhold_q   <= '0;
      sd_q      <= 1'b0;
      ws_prev_q <= 1'b0;
    end else begin
      shreg_q   <= shreg_d;
      rhold_q   <= rhold_d;
      sd_q      <= sd_d;
      ws_prev_q <= ws_prev_d;
    end
  end

  assign sd_o = sd_q;

  assert_pop_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (active && !fifo_empty));

  assert_sd_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sd_o));

endmodule

// File: rtl/i2s_tx_core.sv
module i2s_tx_core
  import i2stx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sck_i,
  input  logic              ws_i,
  output logic              sd_o,
  output logic              irq_o,
  output logic              fifo_low_o,
  output logic              overrun_o
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [1:0]          rst_pipe;
  logic                rst_core_n;
  enables_t            en;
  logic [2:0]          res_code;
  logic                push, pop, flush, full, empty;
  logic [2*DATA_W-1:0] push_data, head;
  logic [LVL_W-1:0]    level;
  logic                active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign active = en.glb && en.blk && en.ch;

  i2stx_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .fifo_level(level), .fifo_full(full), .en(en), .res_code(res_code),
    .push(push), .push_data(push_data), .flush(flush),
    .low_flag(fifo_low_o), .ovr_flag(overrun_o), .irq(irq_o)
  );

  i2stx_fifo #(.WIDTH(2*DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(push), .push_data(push_data),
    .pop(pop), .flush(flush), .head(head), .level(level),
    .full(full), .empty(empty)
  );

  i2stx_serial #(.SLOT(DATA_W), .SYNC(SYNC_STAGES)) u_serial (
    .clk(clk), .rst_n(rst_core_n), .sck_i(sck_i), .ws_i(ws_i),
    .active(active), .fifo_empty(empty), .head(head), .res_code(res_code),
    .pop(pop), .sd_o(sd_o)
  );

endmodule

// File: tb/sim_i2s_tx_core.sv
module sim_i2s_tx_core;

  localparam int DEPTH = 8;
  localparam int FRAME = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [8:0]  addr;
  logic [31:0] wdata, rdata;
  logic        sck, ws;
  logic        sd, irq, low, ovr;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] rxw[$];
  logic        rxc[$];
  logic [31:0] acc;
  logic [31:0] pl[16];
  logic [31:0] pr[16];

  always #2 clk = ~clk;

  i2s_tx_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck_i(sck), .ws_i(ws), .sd_o(sd),
    .irq_o(irq), .fifo_low_o(low), .overrun_o(ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wbits(input logic [2:0] c);
    case (c)
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] expw(input logic [2:0] c, input logic [31:0] s);
    return s << (32 - wbits(c));
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_en(input logic g, input logic b, input logic c);
    wr(9'h000, {31'd0, g}); wr(9'h008, {31'd0, b}); wr(9'h02C, {31'd0, c});
  endtask

  // bit clock and word select source plus a receiver decoding sd
  initial begin
    sck = 1'b0; ws = 1'b1; acc = '0;
    forever begin
      for (int b = 0; b < 32; b++) begin
        for (int p = 0; p < 8; p++) begin
          @(negedge clk);
          if (p == 0) begin
            sck = 1'b0;
            if (b == 0) ws = ~ws;
          end
          if (p == 4) begin
            if (b == 0) begin
              rxw.push_back({acc[30:0], sd});
              rxc.push_back(~ws);
              acc = '0;
            end else begin
              acc = {acc[30:0], sd};
            end
            sck = 1'b1;
          end
        end
      end
    end
  end

  task automatic fill(input logic [2:0] c, input int n);
    for (int k = 0; k < n; k++) begin
      pl[k] = $urandom | (32'h1 << (wbits(c) - 1));
      pr[k] = $urandom | (32'h1 << (wbits(c) - 1));
      wr(9'h020, pl[k]);
      wr(9'h024, pr[k]);
    end
  endtask

  task automatic verify(input logic [2:0] c, input int n);
    int i;
    i = -1;
    for (int k = 0; k < rxw.size(); k++)
      if (i < 0 && rxc[k] == 1'b0 && rxw[k] != 0) i = k;
    chk("R4 stream start found", (i >= 0), 1);
    if (i >= 0) begin
      chk("R3 word count", (rxw.size() >= i + 2*n + 2), 1);
      if (rxw.size() >= i + 2*n + 2) begin
        for (int k = 0; k < n; k++) begin
          chk("R4 R5 left word", rxw[i+2*k], expw(c, pl[k]));
          chk("R4 left on ws low", {31'd0, rxc[i+2*k]}, 0);
          chk("R5 right word", rxw[i+2*k+1], expw(c, pr[k]));
        end
        chk("R7 zero left when empty", rxw[i+2*n], 0);
        chk("R7 zero right when empty", rxw[i+2*n+1], 0);
      end
    end
  endtask

  task automatic round(input logic [2:0] c, input int n);
    set_en(1'b0, 1'b0, 1'b0);
    wr(9'h018, 32'd1);
    wr(9'h034, {29'd0, c});
    fill(c, n);
    rxw.delete(); rxc.delete();
    set_en(1'b1, 1'b1, 1'b1);
    repeat ((n + 3) * FRAME) @(negedge clk);
    wr(9'h02C, 32'd0);
    verify(c, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, r;
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 sd", {31'd0, sd}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(9'h000, v); chk("R1 global enable", v, 0);
    rd(9'h008, v); chk("R1 block enable", v, 0);
    rd(9'h02C, v); chk("R1 channel enable", v, 0);
    rd(9'h034, v); chk("R1 width code", v, 32'd2);
    rd(9'h03C, v); chk("R1 mask", v, 32'h30);
    rd(9'h04C, v); chk("R1 threshold", v, 0);
    rd(9'h038, v); chk("R1 status", v, 32'h10);

    // R2 enable readback
    for (int k = 0; k < 4; k++) begin
      r = $urandom;
      wr(9'h000, r); rd(9'h000, v); chk("R2 global enable", v, {31'd0, r[0]});
      r = $urandom;
      wr(9'h008, r); rd(9'h008, v); chk("R2 block enable", v, {31'd0, r[0]});
      r = $urandom;
      wr(9'h02C, r); rd(9'h02C, v); chk("R2 channel enable", v, {31'd0, r[0]});
    end
    set_en(1'b0, 1'b0, 1'b0);

    // R3 R4 R5 R7 directed width codes
    round(3'd2, 3);
    round(3'd4, 2);
    round(3'd5, 2);
    round(3'd3, 1);
    // random rounds
    for (int k = 0; k < 5; k++) begin
      logic [2:0] cc;
      cc = 3'($urandom % 8);
      round(cc, 1 + int'($urandom % DEPTH));
    end

    // R6 one enable missing: nothing sent, nothing popped
    for (int m = 0; m < 3; m++) begin
      set_en(1'b0, 1'b0, 1'b0);
      wr(9'h018, 32'd1);
      wr(9'h04C, 32'd0);
      wr(9'h034, 32'd5);
      fill(3'd5, 1);
      rxw.delete(); rxc.delete();
      set_en(m != 0, m != 1, m != 2);
      repeat (3 * FRAME) @(negedge clk);
      v = 0;
      for (int k = 0; k < rxw.size(); k++) v = v | rxw[k];
      chk("R6 no data while gated", v, 0);
      chk("R6 level kept while gated", {31'd0, low}, 0);
    end
    set_en(1'b0, 1'b0, 1'b0);

    // R8 threshold, R10 masking, R11 flush
    wr(9'h018, 32'd1);
    wr(9'h04C, 32'd2);
    for (int k = 0; k < 4; k++) begin
      chk("R8 low flag vs level", {31'd0, low}, (k <= 2) ? 1 : 0);
      rd(9'h038, v); chk("R8 status bit4", v & 32'h10, (k <= 2) ? 32'h10 : 0);
      wr(9'h020, 32'h1); wr(9'h024, 32'h2);
    end
    wr(9'h04C, 32'd8);
    wr(9'h03C, 32'h20);
    chk("R10 irq threshold unmasked", {31'd0, irq}, 1);
    wr(9'h03C, 32'h30);
    chk("R10 irq all masked", {31'd0, irq}, 0);
    wr(9'h04C, 32'd0);
    wr(9'h018, 32'd0);
    chk("R11 flush write of 0 ignored", {31'd0, low}, 0);
    wr(9'h018, 32'd1);
    chk("R11 flush empties", {31'd0, low}, 1);

    // R9 overrun: full FIFO discards, flag, clears, irq
    wr(9'h034, 32'd2);
    fill(3'd2, DEPTH);
    chk("R9 no overrun at depth", {31'd0, ovr}, 0);
    wr(9'h020, 32'hAAAA); wr(9'h024, 32'h5555);
    chk("R9 overrun set", {31'd0, ovr}, 1);
    rd(9'h038, v); chk("R9 status bit5", v & 32'h20, 32'h20);
    chk("R10 overrun masked", {31'd0, irq}, 0);
    wr(9'h03C, 32'h10);
    chk("R10 overrun unmasked irq", {31'd0, irq}, 1);
    rd(9'h044, v);
    chk("R9 read clears overrun", {31'd0, ovr}, 0);
    wr(9'h03C, 32'h30);
    rxw.delete(); rxc.delete();
    set_en(1'b1, 1'b1, 1'b1);
    repeat ((DEPTH + 3) * FRAME) @(negedge clk);
    wr(9'h02C, 32'd0);
    verify(3'd2, DEPTH);
    fill(3'd2, DEPTH);
    wr(9'h024, 32'h1234);
    chk("R9 overrun set again", {31'd0, ovr}, 1);
    wr(9'h044, 32'd0);
    chk("R9 write clears overrun", {31'd0, ovr}, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule